// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is the target side of a JTAG data register that reaches a small bank of 32-bit debug registers. Every scan moves a 38-bit frame through the chain, least significant bit first from `tdi` toward `tdo`. The first 32 bits shifted in are a data word, the next 5 are a register address and the last bit is a direction flag. When Update-DR is reached, the frame either stores the data word into the addressed register or marks that register to be read. The read value is loaded into the data field at the following Capture-DR, so it leaves the chain during the next scan. A host therefore always finishes a read burst with one more scan.

The bank holds several registers. A debug control register carries a monitor-mode enable. A debug status word is supplied by the core. A vector catch register stores catch enables. Two watch units each hold value/mask pairs for address, data and control. A comms mailbox sits in both directions. Reading the mailbox data register pops a word from the target, so a read burst must not leave its address on that register for the closing scan. The comms control register is safe to read at any time and is the usual target of that closing scan.

Top module: `dbg_scan_chain`

## Requirements
- R1: While `trst_n` is low, `tdo` is 0 and every register output is 0. The first capture after reset loads a data field of zero.
- R2: Frame bit i is shifted in on the i-th Shift-DR clock. Bits 0 to 31 form the data word, bits 32 to 36 the address and bit 37 the direction flag. Register outputs change only on a clock with `update_dr` high; a scan without an update leaves them unchanged.
- R3: A frame whose flag is 1 writes its data word into the register at its address. The register output shows the new value one clock after the update clock.
- R4: A frame whose flag is 0 selects its address. At the next Capture-DR that register's value is loaded into data bits 0 to 31. Data bit i then appears on `tdo` before the i-th shift clock of the following scan.
- R5: Address map: 0x00 debug control, 0x01 debug status (read only, from `dbg_status_i`), 0x02 vector catch, 0x04 comms control (read only, from `comms_ctrl_i`), 0x05 comms data. Watch unit u owns addresses 8*(u+1) through 8*(u+1)+5 in the order address value, address mask, data value, data mask, control value, control mask. Watch register r of unit u appears on `watch_o` bits [(6u+r)*32 +: 32].
- R6: Debug control keeps only its low DCTRL_W bits, which are 6 by default, and upper bits read as zero. Bit 4 drives `mon_en_o`.
- R7: Writes to unmapped addresses change nothing, and reads of them return zero.
- R8: `comms_rx_pop_o` pulses for exactly the capture clock of a scan that follows a read of 0x05. That capture loads `comms_rx_i`. Reading 0x04 never pops.
- R9: A write to 0x05 pulses `comms_tx_push_o` on the update clock with the data word on `comms_tx_o`. Writes to 0x01 and 0x04 are ignored.
- R10: A capture that does not follow a read update, for example after a write scan, loads zero. Each read selection is sampled by one capture only.
- R11: Vector catch keeps its low VC_W bits, which are 8 by default, and the rest read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| capture_dr | input | 1 | TAP is in Capture-DR for this chain |
| shift_dr | input | 1 | TAP is in Shift-DR for this chain |
| update_dr | input | 1 | TAP is in Update-DR for this chain |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| dbg_status_i | input | DSTAT_W | Debug status from the core |
| dbg_ctrl_o | output | DCTRL_W | Debug control register |
| mon_en_o | output | 1 | Monitor-mode enable (control bit 4) |
| vcatch_o | output | VC_W | Vector catch enables |
| watch_o | output | WP_UNITS*192 | All watch unit registers |
| comms_ctrl_i | input | 32 | Comms control word from the mailbox |
| comms_rx_i | input | 32 | Head of the target-to-host mailbox |
| comms_rx_pop_o | output | 1 | Pop strobe for the target-to-host mailbox |
| comms_tx_o | output | 32 | Word for the host-to-target mailbox |
| comms_tx_push_o | output | 1 | Push strobe for the host-to-target mailbox |

## Verification
A write takes effect one clock after its update clock, so the bench reads register outputs at the falling edge that follows that clock. A read is due one scan later: its value is taken from `tdo` at the falling edges of the next scan's shift phase, bit i before shift clock i. The bench's expected values therefore always refer to the address sent in the previous scan. Mailbox pops happen on the capture clock, and the bench's own mailbox model advances at that same edge. This lets each expected comms word be computed from the number of pops so far, and every burst of reads ends with a scan of the comms control register.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int FRAME_W = DATA_W + ADDR_W + 1;
  localparam int WP_REGS = 6;

  localparam logic [ADDR_W-1:0] A_DCTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_DSTAT  = 5'h01;
  localparam logic [ADDR_W-1:0] A_VCATCH = 5'h02;
  localparam logic [ADDR_W-1:0] A_CCTRL  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CDATA  = 5'h05;

  // bit FRAME_W-1 is the direction flag, data occupies the low bits
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic logic [ADDR_W-1:0] wp_addr(input int unit, input int idx);
    return ADDR_W'(8 * (unit + 1) + idx);
  endfunction
endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dsc_shifter.sv
module dsc_shifter
  import dsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              shift,
  input  logic              din,
  input  logic [DATA_W-1:0] cap_data,
  output frame_t            frame,
  output logic              dout
);
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               sr_en;

  assign sr_en = cap | shift;

  always_comb begin
    sr_d = sr_q;
    if (cap)        sr_d = {{(FRAME_W-DATA_W){1'b0}}, cap_data};
    else if (shift) sr_d = {din, sr_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign frame = frame_t'(sr_q);
  assign dout  = sr_q[0];
endmodule

// File: rtl/dsc_decode.sv
module dsc_decode
  import dsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              upd,
  input  frame_t            frame,
  input  logic [DATA_W-1:0] bank_rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              rx_pop,
  output logic              tx_push
);
  logic              sel_vld_q, sel_vld_d;
  logic [ADDR_W-1:0] sel_addr_q, sel_addr_d;
  logic              sel_en;

  assign sel_en = upd | cap;

  always_comb begin
    sel_vld_d  = sel_vld_q;
    sel_addr_d = sel_addr_q;
    if (upd) begin
      sel_vld_d  = ~frame.wr;
      sel_addr_d = frame.addr;
    end else if (cap) begin
      sel_vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld_q  <= 1'b0;
      sel_addr_q <= '0;
    end else if (sel_en) begin
      sel_vld_q  <= sel_vld_d;
      sel_addr_q <= sel_addr_d;
    end
  end

  assign wr_en    = upd & frame.wr;
  assign rd_addr  = sel_addr_q;
  assign cap_data = sel_vld_q ? bank_rd_data : '0;
  assign rx_pop   = cap & sel_vld_q & (sel_addr_q == A_CDATA);
  assign tx_push  = wr_en & (frame.addr == A_CDATA);
endmodule

// File: rtl/dsc_regbank.sv
module dsc_regbank
  import dsc_pkg::*;
#(
  parameter int DCTRL_W  = 6,
  parameter int DSTAT_W  = 5,
  parameter int VC_W     = 8,
  parameter int WP_UNITS = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic [DSTAT_W-1:0]                  stat_i,
  input  logic [DATA_W-1:0]                   cctrl_i,
  input  logic [DATA_W-1:0]                   rx_i,
  output logic [DATA_W-1:0]                   rd_data,
  output logic [DCTRL_W-1:0]                  dctrl_q,
  output logic [VC_W-1:0]                     vc_q,
  output logic [WP_UNITS*WP_REGS*DATA_W-1:0]  wp_flat
);
  localparam int NWP = WP_UNITS * WP_REGS;

  logic              dctrl_en, vc_en;
  logic [DATA_W-1:0] wp_q [NWP];

  assign dctrl_en = wr_en & (wr_addr == A_DCTRL);
  assign vc_en    = wr_en & (wr_addr == A_VCATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dctrl_q <= '0;
    else if (dctrl_en) dctrl_q <= wr_data[DCTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vc_q <= '0;
    else if (vc_en) vc_q <= wr_data[VC_W-1:0];
  end

  for (genvar u = 0; u < WP_UNITS; u++) begin : g_unit
    for (genvar r = 0; r < WP_REGS; r++) begin : g_reg
      localparam int IDX = u * WP_REGS + r;
      logic en;
      assign en = wr_en & (wr_addr == wp_addr(u, r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  wp_q[IDX] <= '0;
        else if (en) wp_q[IDX] <= wr_data;
      end
      assign wp_flat[IDX*DATA_W +: DATA_W] = wp_q[IDX];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_DCTRL:  rd_data = DATA_W'(dctrl_q);
      A_DSTAT:  rd_data = DATA_W'(stat_i);
      A_VCATCH: rd_data = DATA_W'(vc_q);
      A_CCTRL:  rd_data = cctrl_i;
      A_CDATA:  rd_data = rx_i;
      default: begin
        for (int i = 0; i < NWP; i++) begin
          if (rd_addr == wp_addr(i / WP_REGS, i % WP_REGS)) rd_data = wp_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
  import dsc_pkg::*;
#(
  parameter int DCTRL_W  = 6,
  parameter int DSTAT_W  = 5,
  parameter int VC_W     = 8,
  parameter int WP_UNITS = 2
) (
  input  logic                                tck,
  input  logic                                trst_n,
  input  logic                                capture_dr,
  input  logic                                shift_dr,
  input  logic                                update_dr,
  input  logic                                tdi,
  output logic                                tdo,
  input  logic [DSTAT_W-1:0]                  dbg_status_i,
  output logic [DCTRL_W-1:0]                  dbg_ctrl_o,
  output logic                                mon_en_o,
  output logic [VC_W-1:0]                     vcatch_o,
  output logic [WP_UNITS*WP_REGS*DATA_W-1:0]  watch_o,
  input  logic [DATA_W-1:0]                   comms_ctrl_i,
  input  logic [DATA_W-1:0]                   comms_rx_i,
  output logic                                comms_rx_pop_o,
  output logic [DATA_W-1:0]                   comms_tx_o,
  output logic                                comms_tx_push_o
);
  localparam int MON_BIT = 4;

  logic              rst_n;
  frame_t            frame;
  logic [DATA_W-1:0] cap_data, bank_rd;
  logic              wr_en;
  logic [ADDR_W-1:0] rd_addr;

  dsc_rst_sync u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .srst_n (rst_n)
  );

  dsc_shifter u_shift (
    .clk      (tck),
    .rst_n    (rst_n),
    .cap      (capture_dr),
    .shift    (shift_dr),
    .din      (tdi),
    .cap_data (cap_data),
    .frame    (frame),
    .dout     (tdo)
  );

  dsc_decode u_dec (
    .clk          (tck),
    .rst_n        (rst_n),
    .cap          (capture_dr),
    .upd          (update_dr),
    .frame        (frame),
    .bank_rd_data (bank_rd),
    .wr_en        (wr_en),
    .rd_addr      (rd_addr),
    .cap_data     (cap_data),
    .rx_pop       (comms_rx_pop_o),
    .tx_push      (comms_tx_push_o)
  );

  dsc_regbank #(
    .DCTRL_W  (DCTRL_W),
    .DSTAT_W  (DSTAT_W),
    .VC_W     (VC_W),
    .WP_UNITS (WP_UNITS)
  ) u_bank (
    .clk     (tck),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (frame.addr),
    .wr_data (frame.data),
    .rd_addr (rd_addr),
    .stat_i  (dbg_status_i),
    .cctrl_i (comms_ctrl_i),
    .rx_i    (comms_rx_i),
    .rd_data (bank_rd),
    .dctrl_q (dbg_ctrl_o),
    .vc_q    (vcatch_o),
    .wp_flat (watch_o)
  );

  assign mon_en_o   = dbg_ctrl_o[MON_BIT];
  assign comms_tx_o = frame.data;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int DCTRL_W = 6,
  parameter int WATCH_W = 384
) (
  input logic               tck,
  input logic               trst_n,
  input logic               capture_dr,
  input logic               update_dr,
  input logic               tdo,
  input logic [DCTRL_W-1:0] dbg_ctrl_o,
  input logic [WATCH_W-1:0] watch_o,
  input logic               comms_rx_pop_o,
  input logic               comms_tx_push_o
);
  always @(negedge tck) begin
    if (!trst_n) begin
      p_tdo_low_in_reset_r1: assert (tdo == 1'b0);
    end
  end

  p_ctrl_needs_update_r2: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable(dbg_ctrl_o));

  p_watch_needs_update_r3: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable(watch_o));

  p_pop_in_capture_r8: assert property (@(posedge tck) disable iff (!trst_n)
    comms_rx_pop_o |-> capture_dr);

  p_push_in_update_r9: assert property (@(posedge tck) disable iff (!trst_n)
    comms_tx_push_o |-> update_dr);

  p_strobes_exclusive_r8: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({comms_rx_pop_o, comms_tx_push_o}));
endmodule

bind dbg_scan_chain dsc_checker #(
  .DCTRL_W (DCTRL_W),
  .WATCH_W (WP_UNITS*dsc_pkg::WP_REGS*dsc_pkg::DATA_W)
) u_chk (
  .tck             (tck),
  .trst_n          (trst_n),
  .capture_dr      (capture_dr),
  .update_dr       (update_dr),
  .tdo             (tdo),
  .dbg_ctrl_o      (dbg_ctrl_o),
  .watch_o         (watch_o),
  .comms_rx_pop_o  (comms_rx_pop_o),
  .comms_tx_push_o (comms_tx_push_o)
);

// File: tb/test_dbg_scan_chain.sv
module test_dbg_scan_chain;
  localparam int NW = 2 * 6 * 32;
  localparam logic [4:0]  STAT  = 5'h15;
  localparam logic [31:0] CCTRL = 32'h3000_0002;

  logic tck = 0, trst_n = 0, cap = 0, shf = 0, upd = 0, tdi = 0;
  logic tdo, mon, pop, push;
  logic [5:0]  dctrl;
  logic [7:0]  vc;
  logic [NW-1:0] watch;
  logic [31:0] rx, txd;
  int errors = 0, checks = 0, pops = 0, pushes = 0;
  logic [31:0] last_tx = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  dbg_scan_chain i_dbg_scan_chain (
    .tck(tck), .trst_n(trst_n), .capture_dr(cap), .shift_dr(shf), .update_dr(upd),
    .tdi(tdi), .tdo(tdo), .dbg_status_i(STAT), .dbg_ctrl_o(dctrl), .mon_en_o(mon),
    .vcatch_o(vc), .watch_o(watch), .comms_ctrl_i(CCTRL), .comms_rx_i(rx),
    .comms_rx_pop_o(pop), .comms_tx_o(txd), .comms_tx_push_o(push));

  // mailbox models
  assign rx = 32'hC0DE_0000 + 32'(pops);
  always @(posedge tck) begin
    if (pop) pops <= pops + 1;
    if (push) begin pushes <= pushes + 1; last_tx <= txd; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full scan; returns the captured data field
  task automatic scan(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      input bit do_upd, output logic [31:0] got);
    logic [37:0] f = {wr, a, d};
    @(negedge tck) cap = 1;
    @(negedge tck) cap = 0; shf = 1;
    for (int i = 0; i < 38; i++) begin
      if (i < 32) got[i] = tdo;
      tdi = f[i];
      @(negedge tck);
    end
    shf = 0; upd = do_upd;
    @(negedge tck) upd = 0;
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'h9E37_79B9 * 32'(a + 1);
  endfunction

  function automatic bit is_watch(input int a);
    return (a >= 8 && a <= 13) || (a >= 16 && a <= 21);
  endfunction

  function automatic logic [31:0] expect_rd(input int a, input int npop);
    if (a == 0) return pat(0) & 32'h3F;
    if (a == 1) return 32'(STAT);
    if (a == 2) return pat(2) & 32'hFF;
    if (a == 4) return CCTRL;
    if (a == 5) return 32'hC0DE_0000 + 32'(npop);
    if (is_watch(a)) return pat(a);
    return 32'h0;
  endfunction

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    int p0;
    repeat (3) @(negedge tck);
    check("R1 tdo in reset", 32'(tdo), 0);
    check("R1 ctrl in reset", 32'(dctrl), 0);
    check("R1 watch in reset", 32'(|watch), 0);
    trst_n = 1;
    repeat (3) @(negedge tck);

    // write sweep over every address
    for (int a = 0; a < 32; a++) begin
      scan(1'b1, 5'(a), pat(a), 1'b1, got);
      if (a == 0) check("R1 first capture zero", got, 0);
      else        check("R10 capture after write zero", got, 0);
      if (a == 0) check("R3 ctrl written", 32'(dctrl), pat(0) & 32'h3F);
      if (a == 5) begin
        check("R9 push count", 32'(pushes), 1);
        check("R9 pushed data", last_tx, pat(5));
      end
    end
    check("R9 single push", 32'(pushes), 1);
    check("R11 vcatch port", 32'(vc), pat(2) & 32'hFF);
    check("R6 mon_en", 32'(mon), 32'(pat(0)[4]));
    for (int u = 0; u < 2; u++)
      for (int r = 0; r < 6; r++)
        check("R5 watch port", watch[(u*6+r)*32 +: 32], pat(8*(u+1)+r));

    // pipelined read sweep, closing with comms control
    p0 = pops;
    scan(1'b0, 5'd0, 32'hFFFF_FFFF, 1'b1, got);
    check("R10 capture after write zero", got, 0);
    for (int a = 1; a <= 32; a++) begin
      scan(1'b0, (a == 32) ? 5'd4 : 5'(a), 32'h0, 1'b1, got);
      if (a - 1 == 5 || a - 1 == 6) ;
      check(is_watch(a-1) ? "R5 watch read" :
            (a-1 == 0 ? "R6 ctrl read" : (a-1 == 2 ? "R11 vc read" :
            (a-1 == 5 ? "R8 rx read" : (a-1 < 5 ? "R5 map read" : "R7 unmapped read")))),
            got, expect_rd(a - 1, p0));
    end
    check("R8 one pop in sweep", 32'(pops - p0), 1);
    scan(1'b0, 5'd4, 32'h0, 1'b1, got);
    check("R4 comms ctrl read", got, CCTRL);
    check("R8 ctrl read no pop", 32'(pops - p0), 1);

    // back-to-back mailbox reads
    p0 = pops;
    scan(1'b0, 5'd5, 32'h0, 1'b1, got);
    scan(1'b0, 5'd5, 32'h0, 1'b1, got);
    check("R8 first pop data", got, 32'hC0DE_0000 + 32'(p0));
    scan(1'b0, 5'd4, 32'h0, 1'b1, got);
    check("R8 second pop data", got, 32'hC0DE_0000 + 32'(p0 + 1));
    check("R8 two pops", 32'(pops - p0), 2);

    // monitor enable and width
    scan(1'b1, 5'd0, 32'h0000_0010, 1'b1, got);
    check("R6 mon set", 32'(mon), 1);
    scan(1'b1, 5'd0, 32'hFFFF_FFEF, 1'b1, got);
    check("R6 mon clear", 32'(mon), 0);
    check("R6 ctrl width", 32'(dctrl), 32'h2F);
    scan(1'b0, 5'd0, 32'h0, 1'b1, got);
    scan(1'b0, 5'd4, 32'h0, 1'b1, got);
    check("R6 ctrl upper zero", got, 32'h2F);

    // scan without update changes nothing
    scan(1'b1, 5'd0, 32'h0, 1'b0, got);
    check("R2 no update keeps ctrl", 32'(dctrl), 32'h2F);
    scan(1'b1, 5'd8, 32'h0, 1'b0, got);
    check("R2 no update keeps watch", watch[31:0], pat(8));

    // unmapped write leaves watch and ctrl alone
    scan(1'b1, 5'd31, 32'hDEAD_BEEF, 1'b1, got);
    check("R7 unmapped write ctrl", 32'(dctrl), 32'h2F);
    check("R7 unmapped write watch", watch[NW-1 -: 32], pat(21));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule